// File: doc/BRIEF.md
# Serial Display Register Interface

This block is the host-facing serial port of a display controller. A host talks to it over a four-wire SPI link in mode 0 (clock idles low, data sampled on the rising edge, shifted on the falling edge, MSB first). Every transaction is framed by chip select low. It carries exactly two bytes. The first byte is a cycle-type prefix. The second byte is either a payload from the host or, on read cycles, a dummy byte during which the block shifts its answer out.

A command cycle loads a register pointer. That pointer stays in place across any number of later transactions. Data-write cycles store their payload into the register the pointer selects. Data-read cycles return that register's contents. Status-read cycles return the drawing engine's status byte without consulting the pointer. One pointer value is reserved as the pixel-memory port: data bytes written while it is selected leave the block on a valid/ready byte stream instead of reaching the register file.

The serial side runs on the host's serial clock. Received bytes move into the system clock domain through toggle handshakes. The host must keep each serial clock half period at least six system clock cycles long, so that a read answer is ready before its first bit is due.

Top module: `serial_regif`

## Requirements
- R1: While reset is asserted and after its release, `rf_we` and `px_valid` are low, `rf_addr` is 0x00, and `miso` is low while chip select is high.
- R2: The cycle type is decoded from prefix bits [7:6] only: 2'b10 command write, 2'b00 data write, 2'b11 status read, 2'b01 data read. Prefix bits [5:0] are ignored, so 0x80, 0x00, 0xC0 and 0x40 are the canonical values.
- R3: A command write sets `rf_addr` to its payload and produces no `rf_we` pulse.
- R4: A data write to any address other than `MEMPORT_ADDR` produces exactly one single-cycle `rf_we` pulse, with `rf_wdata` equal to the payload and `rf_addr` equal to the current pointer. The pointer persists, so consecutive data writes land in the same register.
- R5: A data read shifts out on `miso` the value of `rf_rdata` for the current pointer, MSB first, during the second byte. Each bit is valid at the rising serial clock edge on which the host samples it.
- R6: A status read returns `stat_in` (bit 7 = memory clear still running) during the second byte, whatever the pointer holds.
- R7: A transaction in which chip select rises before all 16 bits have arrived is discarded. The pointer and all registers are left unchanged.
- R8: A data write while `rf_addr` equals `MEMPORT_ADDR` produces no `rf_we`. It appends the payload to a `PX_DEPTH`-entry pixel queue, which is presented on `px_data` in arrival order.
- R9: Back-pressure: while `px_valid` is high and `px_ready` is low, `px_valid` stays high and `px_data` holds. A pixel byte that arrives while the queue is full is dropped, because the serial link cannot be stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host (mode 0) |
| cs_n | input | 1 | Active-low chip select, frames one transaction |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| stat_in | input | 8 | Status byte from drawing logic; bit 7 = memory clear busy |
| rf_addr | output | 8 | Current register pointer, also the register-file read address |
| rf_we | output | 1 | Register-file write strobe, one cycle |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data for `rf_addr` |
| px_valid | output | 1 | Pixel byte available |
| px_ready | input | 1 | Pixel consumer accepts the byte |
| px_data | output | 8 | Pixel byte |

## Verification
A corrupted pointer shows at the ports in the same transaction that corrupts it, because `rf_addr` is a port. The next data write or data read then goes to the wrong register, which shows as a wrong read-back value within one or two transactions. A wrong decode of the cycle type shows either as a missing or extra `rf_we` pulse a few system clocks after chip select rises, or as a wrong byte on `miso` during the very next read. A broken pixel queue pointer shows as reordered, repeated or missing bytes on `px_data`, or as `px_valid` staying high after the expected bytes have been drained.

// File: rtl/serial_regif_pkg.sv
`timescale 1ns/1ps
package serial_regif_pkg;
  localparam int BYTE_W = 8;

  // cycle type taken from prefix bits [7:6]
  typedef enum logic [1:0] {
    CYC_DWR  = 2'b00,
    CYC_DRD  = 2'b01,
    CYC_CMD  = 2'b10,
    CYC_STAT = 2'b11
  } cyc_e;

  function automatic cyc_e cyc_of(input logic [1:0] top);
    return cyc_e'(top);
  endfunction

  // both read types carry a 1 in prefix bit 6
  function automatic logic cyc_is_read(input logic [1:0] top);
    return top[0];
  endfunction
endpackage

// File: rtl/sri_sclk_front.sv
`timescale 1ns/1ps
module sri_sclk_front
  import serial_regif_pkg::*;
(
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] rsp_byte,
  output logic              miso,
  output logic              pfx_tgl,
  output logic [1:0]        pfx_cyc,
  output logic              frm_tgl,
  output logic [1:0]        frm_cyc,
  output logic [BYTE_W-1:0] frm_pay
);
  localparam int CNT_W = $clog2(2*BYTE_W + 1);
  localparam logic [CNT_W-1:0] PFX_LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] RSP_FIRST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] PAY_LAST  = CNT_W'(2*BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_DONE  = CNT_W'(2*BYTE_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] rx_next;
  logic [BYTE_W-1:0] tx_sh;
  logic              miso_q;

  assign rx_next = {rx_sh[BYTE_W-2:0], mosi};

  // bit counter and receive shifter, cleared whenever chip select is high
  always_ff @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else begin
      rx_sh <= rx_next;
      if (bit_cnt != CNT_DONE) bit_cnt <= bit_cnt + CNT_W'(1);
    end
  end

  // hand-off registers; each toggle flips once its data is stable
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_tgl <= 1'b0;
      pfx_cyc <= '0;
      frm_tgl <= 1'b0;
      frm_cyc <= '0;
      frm_pay <= '0;
    end else begin
      if (bit_cnt == PFX_LAST) begin
        pfx_cyc <= rx_next[BYTE_W-1 -: 2];
        pfx_tgl <= ~pfx_tgl;
      end
      if (bit_cnt == PAY_LAST) begin
        frm_cyc <= pfx_cyc;
        frm_pay <= rx_next;
        frm_tgl <= ~frm_tgl;
      end
    end
  end

  // response shifter, launched on falling edges
  always_ff @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      miso_q <= 1'b0;
      tx_sh  <= '0;
    end else if (bit_cnt == RSP_FIRST) begin
      if (cyc_is_read(pfx_cyc)) begin
        miso_q <= rsp_byte[BYTE_W-1];
        tx_sh  <= {rsp_byte[BYTE_W-2:0], 1'b0};
      end else begin
        miso_q <= 1'b0;
        tx_sh  <= '0;
      end
    end else if (bit_cnt > RSP_FIRST && bit_cnt < CNT_DONE) begin
      miso_q <= tx_sh[BYTE_W-1];
      tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
    end else begin
      miso_q <= 1'b0;
    end
  end

  assign miso = miso_q;
endmodule

// File: rtl/sri_tgl_sync.sv
`timescale 1ns/1ps
module sri_tgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES:0] sync_q;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= tgl_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign pulse = sync_q[STAGES] ^ sync_q[STAGES-1];
endmodule

// File: rtl/sri_reg_ctrl.sv
`timescale 1ns/1ps
module sri_reg_ctrl
  import serial_regif_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MEMPORT_ADDR = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfx_evt,
  input  logic [1:0]        pfx_cyc,
  input  logic              frm_evt,
  input  logic [1:0]        frm_cyc,
  input  logic [BYTE_W-1:0] frm_pay,
  input  logic [BYTE_W-1:0] stat_in,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic [BYTE_W-1:0] rf_addr,
  output logic              rf_we,
  output logic [BYTE_W-1:0] rf_wdata,
  output logic [BYTE_W-1:0] rsp_byte,
  output logic              px_push,
  output logic [BYTE_W-1:0] px_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_addr  <= '0;
      rf_we    <= 1'b0;
      rf_wdata <= '0;
      rsp_byte <= '0;
      px_push  <= 1'b0;
      px_byte  <= '0;
    end else begin
      rf_we   <= 1'b0;
      px_push <= 1'b0;
      // prefix seen: capture the answer before the first response bit
      if (pfx_evt) begin
        case (cyc_of(pfx_cyc))
          CYC_STAT: rsp_byte <= stat_in;
          CYC_DRD:  rsp_byte <= rf_rdata;
          default:  ;
        endcase
      end
      // whole frame seen: apply its effect
      if (frm_evt) begin
        case (cyc_of(frm_cyc))
          CYC_CMD: rf_addr <= frm_pay;
          CYC_DWR: begin
            if (rf_addr == MEMPORT_ADDR) begin
              px_push <= 1'b1;
              px_byte <= frm_pay;
            end else begin
              rf_we    <= 1'b1;
              rf_wdata <= frm_pay;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sri_px_fifo.sv
`timescale 1ns/1ps
module sri_px_fifo
  import serial_regif_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] din,
  output logic              valid,
  input  logic              ready,
  output logic [BYTE_W-1:0] dout
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_p, rd_p;
  logic              full, empty, do_push, do_pop;

  assign empty   = (wr_p == rd_p);
  assign full    = ((wr_p - rd_p) == PW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = !empty && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
    end else begin
      if (do_push) wr_p <= wr_p + PW'(1);
      if (do_pop)  rd_p <= rd_p + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p[AW-1:0]] <= din;
  end

  assign valid = !empty;
  assign dout  = mem[rd_p[AW-1:0]];
endmodule

// File: rtl/serial_regif.sv
`timescale 1ns/1ps
module serial_regif
  import serial_regif_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MEMPORT_ADDR = 8'h02,
  parameter int                PX_DEPTH     = 4,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic [BYTE_W-1:0] stat_in,
  output logic [BYTE_W-1:0] rf_addr,
  output logic              rf_we,
  output logic [BYTE_W-1:0] rf_wdata,
  input  logic [BYTE_W-1:0] rf_rdata,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [BYTE_W-1:0] px_data
);
  logic              pfx_tgl, frm_tgl, pfx_evt, frm_evt, px_push;
  logic [1:0]        pfx_cyc, frm_cyc;
  logic [BYTE_W-1:0] frm_pay, rsp_byte, px_byte;

  sri_sclk_front u_front (
    .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .rsp_byte(rsp_byte), .miso(miso),
    .pfx_tgl(pfx_tgl), .pfx_cyc(pfx_cyc),
    .frm_tgl(frm_tgl), .frm_cyc(frm_cyc), .frm_pay(frm_pay)
  );

  sri_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync_pfx (
    .clk(clk), .rst_n(rst_n), .tgl_in(pfx_tgl), .pulse(pfx_evt)
  );

  sri_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync_frm (
    .clk(clk), .rst_n(rst_n), .tgl_in(frm_tgl), .pulse(frm_evt)
  );

  sri_reg_ctrl #(.MEMPORT_ADDR(MEMPORT_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pfx_evt(pfx_evt), .pfx_cyc(pfx_cyc),
    .frm_evt(frm_evt), .frm_cyc(frm_cyc), .frm_pay(frm_pay),
    .stat_in(stat_in), .rf_rdata(rf_rdata),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .rsp_byte(rsp_byte), .px_push(px_push), .px_byte(px_byte)
  );

  sri_px_fifo #(.DEPTH(PX_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(px_push), .din(px_byte),
    .valid(px_valid), .ready(px_ready), .dout(px_data)
  );
endmodule

// File: rtl/serial_regif_chk.sv
`timescale 1ns/1ps
module serial_regif_chk #(
  parameter logic [7:0] MEMPORT_ADDR = 8'h02
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rf_we,
  input logic [7:0] rf_addr,
  input logic       px_valid,
  input logic       px_ready,
  input logic [7:0] px_data,
  input logic       frm_evt
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!rf_we && !px_valid)); // R1

  AST_ADDR_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rf_addr) |-> $past(frm_evt)); // R7

  AST_CMD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $stable(rf_addr)); // R3

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we); // R4

  AST_MEMPORT_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_addr != MEMPORT_ADDR)); // R8

  AST_PX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_data))); // R9
endmodule

bind serial_regif serial_regif_chk #(.MEMPORT_ADDR(MEMPORT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_addr(rf_addr),
  .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data),
  .frm_evt(frm_evt)
);

// File: tb/sim_serial_regif.sv
`timescale 1ns/1ps
module sim_serial_regif;
  localparam int HP = 40; // serial half period, ns (10 system clocks)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic       miso;
  logic [7:0] stat_in = 8'h81;
  logic [7:0] rf_addr;
  logic       rf_we;
  logic [7:0] rf_wdata;
  logic [7:0] rf_rdata;
  logic       px_valid;
  logic       px_ready = 1'b0;
  logic [7:0] px_data;

  always #2 clk = ~clk;

  serial_regif u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .stat_in(stat_in), .rf_addr(rf_addr), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .px_valid(px_valid),
    .px_ready(px_ready), .px_data(px_data)
  );

  // bench-side register file
  logic [7:0] regs [256];
  int         wcnt = 0;
  logic [7:0] last_wdata = 8'h00;
  assign rf_rdata = regs[rf_addr];

  initial for (int i = 0; i < 256; i++) regs[i] = 8'h00;

  always @(negedge clk) begin
    if (rf_we) begin
      regs[rf_addr] = rf_wdata;
      last_wdata    = rf_wdata;
      wcnt          = wcnt + 1;
    end
  end

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // one framed transaction; nbits < 16 aborts it early
  task automatic spi_xfer(input logic [7:0] b0, input logic [7:0] b1,
                          input int nbits, output logic [7:0] rsp);
    logic [15:0] word;
    word = {b0, b1};
    rsp  = 8'h00;
    cs_n = 1'b0;
    #HP;
    for (int i = 0; i < nbits; i++) begin
      mosi = word[15-i];
      #HP sclk = 1'b1;
      if (i >= 8) rsp = {rsp[6:0], miso};
      #HP sclk = 1'b0;
    end
    #HP cs_n = 1'b1;
    mosi = 1'b0;
    #(2*HP);
    repeat (8) @(negedge clk);
  endtask

  // {prefix, payload, kind, expected}; kind 1 response, 2 write, 3 pointer
  localparam logic [25:0] VEC [13] = '{
    {8'h80, 8'h10, 2'd3, 8'h10},
    {8'h00, 8'hA5, 2'd2, 8'hA5},
    {8'h40, 8'h00, 2'd1, 8'hA5},
    {8'h80, 8'h20, 2'd3, 8'h20},
    {8'h00, 8'h3C, 2'd2, 8'h3C},
    {8'h00, 8'h77, 2'd2, 8'h77},
    {8'h40, 8'h00, 2'd1, 8'h77},
    {8'h80, 8'h10, 2'd3, 8'h10},
    {8'h40, 8'h00, 2'd1, 8'hA5},
    {8'hC0, 8'h00, 2'd1, 8'h81},
    {8'h8F, 8'h30, 2'd3, 8'h30},
    {8'h3F, 8'h5A, 2'd2, 8'h5A},
    {8'h7F, 8'h00, 2'd1, 8'h5A}
  };

  initial begin
    #400_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rsp;
    int         w0;
    logic [7:0] pexp [4];
    pexp = '{8'h11, 8'h22, 8'h33, 8'h44};

    // R1: quiet during and after reset
    repeat (5) @(negedge clk);
    check8("R1 rf_we in reset", {7'd0, rf_we}, 8'h00);
    check8("R1 px_valid in reset", {7'd0, px_valid}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check8("R1 rf_addr", rf_addr, 8'h00);
    check8("R1 miso idle", {7'd0, miso}, 8'h00);
    check8("R1 px_valid", {7'd0, px_valid}, 8'h00);

    // table walk: R3 pointer, R4 writes and persistence, R5/R6 reads, R2 decode (rows 10..12)
    for (int i = 0; i < 13; i++) begin
      w0 = wcnt;
      spi_xfer(VEC[i][25:18], VEC[i][17:10], 16, rsp);
      case (VEC[i][9:8])
        2'd1: check8($sformatf("R5/R6/R2 vec%0d response", i), rsp, VEC[i][7:0]);
        2'd2: begin
          check8($sformatf("R4/R2 vec%0d wdata", i), last_wdata, VEC[i][7:0]);
          check8($sformatf("R4 vec%0d one write", i), 8'(wcnt - w0), 8'd1);
        end
        2'd3: begin
          check8($sformatf("R3/R2 vec%0d pointer", i), rf_addr, VEC[i][7:0]);
          check8($sformatf("R3 vec%0d no write", i), 8'(wcnt - w0), 8'd0);
        end
        default: ;
      endcase
    end

    // R7: aborted transactions leave pointer and registers alone
    w0 = wcnt;
    spi_xfer(8'h80, 8'h55, 12, rsp);
    check8("R7 pointer after aborted command", rf_addr, 8'h30);
    spi_xfer(8'h00, 8'hEE, 13, rsp);
    spi_xfer(8'h00, 8'hEE, 5, rsp);
    check8("R7 no write after aborts", 8'(wcnt - w0), 8'd0);
    spi_xfer(8'h40, 8'h00, 16, rsp);
    check8("R7 register intact", rsp, 8'h5A);

    // R6: status bit 7 follows the input
    stat_in = 8'h80;
    spi_xfer(8'hC0, 8'h00, 16, rsp);
    check8("R6 status busy", rsp, 8'h80);
    stat_in = 8'h01;
    spi_xfer(8'hC0, 8'h00, 16, rsp);
    check8("R6 status idle", rsp, 8'h01);

    // R8/R9: pixel port, back-pressure and overflow drop
    spi_xfer(8'h80, 8'h02, 16, rsp);
    w0 = wcnt;
    spi_xfer(8'h00, 8'h11, 16, rsp);
    spi_xfer(8'h00, 8'h22, 16, rsp);
    spi_xfer(8'h00, 8'h33, 16, rsp);
    spi_xfer(8'h00, 8'h44, 16, rsp);
    spi_xfer(8'h00, 8'h55, 16, rsp);
    spi_xfer(8'h00, 8'h66, 16, rsp);
    check8("R8 no register write", 8'(wcnt - w0), 8'd0);
    check8("R9 valid held", {7'd0, px_valid}, 8'h01);
    check8("R9 data held", px_data, 8'h11);
    for (int k = 0; k < 4; k++) begin
      check8($sformatf("R8 pixel %0d valid", k), {7'd0, px_valid}, 8'h01);
      check8($sformatf("R8 pixel %0d order", k), px_data, pexp[k]);
      px_ready = 1'b1;
      @(negedge clk);
      px_ready = 1'b0;
      @(negedge clk);
    end
    check8("R9 overflow dropped", {7'd0, px_valid}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule